// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block is a first-in-first-out buffer whose write side and read side each run on their own clock. A parameter lets both sides share one clock instead; the pointer synchronizers are then removed, and each flag follows the operation that changed it with no added delay. The data width and the depth come as a pair from a fixed set of shapes. The storage is an inferred memory array with a registered read port.

Each side has a full or empty flag and an almost-full or almost-empty flag with its own threshold. Each side also has a one-cycle error strobe for a rejected request, a reset-busy indicator and a count output. The count shows either the number of stored words or the raw binary pointer. On the read side a first-word-fall-through mode can be selected, so the oldest word waits at the output without being requested. An optional output stage adds one register with its own clock enable and its own reset. That reset loads a programmable value, and a parameter decides whether the reset or the enable wins.

Top module: `dcfifo`

## Requirements
- R1: The shape parameter selects one of these width-by-depth pairs: 4x8192, 9x4096, 18x2048, 36x1024 or 72x512. The data ports and the depth follow that choice.
- R2: Words are returned in the order they were written. The order holds across pointer wrap-around.
- R3: `full` is high when the write side sees DEPTH stored words. A write requested while `full` or `wr_busy` is high is dropped and leaves the pointer and memory unchanged. `wr_err` is then high for the cycle after that request.
- R4: `empty` is high when no word is available. A read requested while `empty` or `rd_busy` is high is dropped and leaves the pointer and count unchanged. `rd_err` is then high for the cycle after that request.
- R5: `almost_full` is high when the write-side occupancy is greater than or equal to AF_THRESH. The threshold can be set from 1 to 8191 and defaults to 256.
- R6: `almost_empty` is high when the read-side occupancy is less than or equal to AE_THRESH. The threshold can be set from 1 to 8191 and defaults to 256.
- R7: `rst` is active-high and synchronous to `wclk`. `wr_busy` and `rd_busy` stay high while `rst` is high and until both domains have left reset. After reset the FIFO is empty, both counts are 0 and `dout` shows RST_VAL.
- R8: With CNT_MODE = occupancy, each count shows the stored words as its own side sees them. With CNT_MODE = pointer, each count shows that side's binary pointer modulo 2*DEPTH.
- R9: With FWFT set, the first word written appears on `dout` and `empty` falls without any `rd_en`. Each accepted `rd_en` then presents the next word.
- R10: With OUT_REG set, `dout` comes one register later and holds while `out_ce` is low. `out_rst` loads RST_VAL. With RST_FIRST set, `out_rst` wins over `out_ce`; otherwise `out_rst` acts only when `out_ce` is high.
- R11: With COMMON_CLK set, flags and counts reflect an operation immediately after the clock edge that performed it. With separate clocks, pointers cross as Gray code through two flops, so a flag may clear a few cycles later.
- R12: A read and a write in the same cycle are both performed when the FIFO is neither empty nor full. The occupancy is then unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock (tie to wclk when COMMON_CLK is set) |
| rst | input | 1 | Active-high reset, synchronous to wclk |
| wr_en | input | 1 | Write request |
| din | input | W | Write data |
| full | output | 1 | No free location |
| almost_full | output | 1 | Occupancy at or above AF_THRESH |
| wr_err | output | 1 | Previous write request was dropped |
| wr_busy | output | 1 | Write side in reset |
| wr_count | output | AW+1 | Write-side occupancy or pointer |
| rd_en | input | 1 | Read request |
| out_ce | input | 1 | Output register enable |
| out_rst | input | 1 | Output register reset to RST_VAL |
| dout | output | W | Read data |
| empty | output | 1 | No word available |
| almost_empty | output | 1 | Occupancy at or below AE_THRESH |
| rd_err | output | 1 | Previous read request was dropped |
| rd_busy | output | 1 | Read side in reset |
| rd_count | output | AW+1 | Read-side occupancy or pointer |

## Verification
The risky coincidence is a read and a write landing on the same clock edge while the FIFO sits at a boundary. At the full boundary the write must be dropped with an error strobe while the read still drains a word. At the empty boundary the write must land while the read is refused. The bench provokes both cases in common-clock mode, and also holds both requests for many cycles at half occupancy. A bench queue model decides each request from the occupancy before the edge. It then predicts the error strobes, flags, counts and output word after the edge, and every prediction is compared at the ports.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef enum logic [2:0] {
    SHAPE_4X8192,
    SHAPE_9X4096,
    SHAPE_18X2048,
    SHAPE_36X1024,
    SHAPE_72X512
  } shape_e;

  typedef enum logic {
    CNT_OCCUPANCY,
    CNT_POINTER
  } cnt_mode_e;

  function automatic int shape_width(shape_e s);
    case (s)
      SHAPE_4X8192:  return 4;
      SHAPE_9X4096:  return 9;
      SHAPE_18X2048: return 18;
      SHAPE_36X1024: return 36;
      default:       return 72;
    endcase
  endfunction

  function automatic int shape_depth(shape_e s);
    case (s)
      SHAPE_4X8192:  return 8192;
      SHAPE_9X4096:  return 4096;
      SHAPE_18X2048: return 2048;
      SHAPE_36X1024: return 1024;
      default:       return 512;
    endcase
  endfunction

  // Widest pointer is 14 bits (8192 entries plus wrap bit).
  function automatic logic [13:0] gray_to_bin(logic [13:0] g);
    logic [13:0] b;
    for (int i = 0; i < 14; i++) b[i] = ^(g >> i);
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W      = 1,
  parameter bit BYPASS = 1'b0,
  parameter bit INIT   = 1'b0
)(
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (BYPASS) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk;
      assign q = d;
    end else begin : g_two_flop
      logic [W-1:0] s1 = {W{INIT}};
      logic [W-1:0] s2 = {W{INIT}};
      always_ff @(posedge clk) begin
        s1 <= d;
        s2 <= s1;
      end
      assign q = s2;
    end
  endgenerate
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side import dcfifo_pkg::*; #(
  parameter int        AW       = 9,
  parameter int        AF       = 256,
  parameter cnt_mode_e CNT_MODE = CNT_OCCUPANCY
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_busy_seen,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_ok,
  output logic          full,
  output logic          almost_full,
  output logic          wr_err,
  output logic          busy,
  output logic [AW:0]   count
);
  localparam int DEPTH = 1 << AW;

  logic [AW:0] wbin, wbin_n, rbin_s, occ;
  logic        busy_q = 1'b1;

  assign rbin_s      = (AW+1)'(gray_to_bin(14'(rgray_s)));
  assign occ         = wbin - rbin_s;
  assign full        = (occ == (AW+1)'(DEPTH));
  assign almost_full = (32'(occ) >= AF);
  assign busy        = busy_q;
  assign wr_ok       = wr_en & ~full & ~busy_q;
  assign wbin_n      = wbin + 1'b1;
  assign waddr       = wbin[AW-1:0];
  assign count       = (CNT_MODE == CNT_POINTER) ? wbin : occ;

  always_ff @(posedge clk) begin
    busy_q <= rst | rd_busy_seen;
    wr_err <= wr_en & (full | busy_q | rst);
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_ok) begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst || busy_q)
    32'(occ) <= DEPTH);
  p_hold_full_r3: assert property (@(posedge clk) disable iff (rst || busy_q)
    full |=> $stable(wbin));
  p_werr_req_r3: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en));
  generate
    if (AF <= DEPTH) begin : g_af_chk
      p_full_in_af_r5: assert property (@(posedge clk) disable iff (rst || busy_q)
        full |-> almost_full);
    end
  endgenerate
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side import dcfifo_pkg::*; #(
  parameter int        AW       = 9,
  parameter int        AE       = 256,
  parameter bit        FWFT     = 1'b0,
  parameter cnt_mode_e CNT_MODE = CNT_OCCUPANCY
)(
  input  logic          clk,
  input  logic          rst_s,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          ram_rd,
  output logic          empty,
  output logic          almost_empty,
  output logic          rd_err,
  output logic          busy,
  output logic [AW:0]   count
);
  logic [AW:0] rbin, rbin_n, wbin_s, rocc, occ_vis;
  logic        ram_empty;
  logic        busy_q = 1'b1;

  assign wbin_s    = (AW+1)'(gray_to_bin(14'(wgray_s)));
  assign rocc      = wbin_s - rbin;
  assign ram_empty = (rocc == '0);
  assign busy      = busy_q;
  assign rbin_n    = rbin + 1'b1;
  assign raddr     = rbin[AW-1:0];

  generate
    if (FWFT) begin : g_fwft
      logic have;
      assign ram_rd  = ~ram_empty & ~busy_q & (~have | rd_en);
      assign empty   = ~have;
      assign occ_vis = rocc + (AW+1)'(have);
      always_ff @(posedge clk) begin
        if (rst_s)       have <= 1'b0;
        else if (ram_rd) have <= 1'b1;
        else if (rd_en)  have <= 1'b0;
      end
    end else begin : g_std
      assign ram_rd  = rd_en & ~ram_empty & ~busy_q;
      assign empty   = ram_empty;
      assign occ_vis = rocc;
    end
  endgenerate

  assign almost_empty = (32'(occ_vis) <= AE);
  assign count        = (CNT_MODE == CNT_POINTER) ? rbin : occ_vis;

  always_ff @(posedge clk) begin
    busy_q <= rst_s;
    rd_err <= rd_en & (empty | busy_q | rst_s);
    if (rst_s) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (ram_rd) begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  p_hold_empty_r4: assert property (@(posedge clk) disable iff (rst_s || busy_q)
    ram_empty |=> $stable(rbin));
  p_rerr_req_r4: assert property (@(posedge clk) disable iff (rst_s)
    rd_err |-> $past(rd_en));
endmodule

// File: rtl/dcfifo_outreg.sv
module dcfifo_outreg #(
  parameter int         W         = 72,
  parameter bit         ENABLE    = 1'b0,
  parameter bit         RST_FIRST = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
)(
  input  logic         clk,
  input  logic         rst_s,
  input  logic         ce,
  input  logic         rst_reg,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (!ENABLE) begin : g_none
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_s, ce, rst_reg};
      assign q = d;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst_s) q <= RST_VAL;
        else if (RST_FIRST) begin
          if (rst_reg)  q <= RST_VAL;
          else if (ce)  q <= d;
        end else if (ce) begin
          q <= rst_reg ? RST_VAL : d;
        end
      end
      if (RST_FIRST) begin : g_chk_rst
        p_rst_first_r10: assert property (@(posedge clk) disable iff (rst_s)
          rst_reg |=> (q == RST_VAL));
      end else begin : g_chk_ce
        p_ce_first_r10: assert property (@(posedge clk) disable iff (rst_s)
          (rst_reg && !ce) |=> $stable(q));
      end
    end
  endgenerate
endmodule

// File: rtl/dcfifo.sv
module dcfifo import dcfifo_pkg::*; #(
  parameter shape_e      SHAPE      = SHAPE_72X512,
  parameter bit          COMMON_CLK = 1'b0,
  parameter bit          FWFT       = 1'b0,
  parameter bit          OUT_REG    = 1'b0,
  parameter bit          RST_FIRST  = 1'b1,
  parameter logic [71:0] RST_VAL    = '0,
  parameter int          AE_THRESH  = 256,
  parameter int          AF_THRESH  = 256,
  parameter cnt_mode_e   CNT_MODE   = CNT_OCCUPANCY,
  localparam int W     = shape_width(SHAPE),
  localparam int DEPTH = shape_depth(SHAPE),
  localparam int AW    = $clog2(DEPTH)
)(
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  din,
  output logic          full,
  output logic          almost_full,
  output logic          wr_err,
  output logic          wr_busy,
  output logic [AW:0]   wr_count,
  input  logic          rd_en,
  input  logic          out_ce,
  input  logic          out_rst,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          almost_empty,
  output logic          rd_err,
  output logic          rd_busy,
  output logic [AW:0]   rd_count
);
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wr_ok, ram_rd, rd_rst_s, rd_busy_seen;
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  mem_q;

  dcfifo_sync #(.W(1), .BYPASS(COMMON_CLK), .INIT(1'b1)) u_rst_to_rd (
    .clk(rclk), .d(rst), .q(rd_rst_s));
  dcfifo_sync #(.W(1), .BYPASS(COMMON_CLK), .INIT(1'b1)) u_busy_to_wr (
    .clk(wclk), .d(rd_busy), .q(rd_busy_seen));
  dcfifo_sync #(.W(AW+1), .BYPASS(COMMON_CLK), .INIT(1'b0)) u_wptr_to_rd (
    .clk(rclk), .d(wgray), .q(wgray_s));
  dcfifo_sync #(.W(AW+1), .BYPASS(COMMON_CLK), .INIT(1'b0)) u_rptr_to_wr (
    .clk(wclk), .d(rgray), .q(rgray_s));

  dcfifo_wr_side #(.AW(AW), .AF(AF_THRESH), .CNT_MODE(CNT_MODE)) u_wr (
    .clk(wclk), .rst(rst), .rd_busy_seen(rd_busy_seen), .wr_en(wr_en),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wr_ok(wr_ok),
    .full(full), .almost_full(almost_full), .wr_err(wr_err),
    .busy(wr_busy), .count(wr_count));

  dcfifo_rd_side #(.AW(AW), .AE(AE_THRESH), .FWFT(FWFT), .CNT_MODE(CNT_MODE)) u_rd (
    .clk(rclk), .rst_s(rd_rst_s), .rd_en(rd_en), .wgray_s(wgray_s),
    .rgray(rgray), .raddr(raddr), .ram_rd(ram_rd), .empty(empty),
    .almost_empty(almost_empty), .rd_err(rd_err), .busy(rd_busy),
    .count(rd_count));

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[waddr] <= din;
  end

  always_ff @(posedge rclk) begin
    if (rd_rst_s)    mem_q <= RST_VAL[W-1:0];
    else if (ram_rd) mem_q <= mem[raddr];
  end

  dcfifo_outreg #(.W(W), .ENABLE(OUT_REG), .RST_FIRST(RST_FIRST),
                  .RST_VAL(RST_VAL[W-1:0])) u_out (
    .clk(rclk), .rst_s(rd_rst_s), .ce(out_ce), .rst_reg(out_rst),
    .d(mem_q), .q(dout));
endmodule

// File: tb/dcfifo_tb.sv
module dcfifo_tb;
  import dcfifo_pkg::*;

  localparam logic [71:0] RSTV = 72'h00_0000_5A5A_0000_A5A5;
  localparam int DEP = 512;

  logic wclk = 1'b0, rclk2 = 1'b0;
  always #2 wclk  = ~wclk;
  always #3 rclk2 = ~rclk2;

  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0, out_ce = 1, out_rst = 0;
  logic [71:0] din = '0, dout;
  logic        full, almost_full, wr_err, wr_busy, empty, almost_empty, rd_err, rd_busy;
  logic [9:0]  wr_count, rd_count;

  dcfifo #(.SHAPE(SHAPE_72X512), .COMMON_CLK(1'b1), .FWFT(1'b0), .OUT_REG(1'b1),
           .RST_FIRST(1'b1), .RST_VAL(RSTV), .AE_THRESH(4), .AF_THRESH(508),
           .CNT_MODE(CNT_OCCUPANCY)) u_dut (
    .wclk(wclk), .rclk(wclk), .rst(rst), .wr_en(wr_en), .din(din),
    .full(full), .almost_full(almost_full), .wr_err(wr_err), .wr_busy(wr_busy),
    .wr_count(wr_count), .rd_en(rd_en), .out_ce(out_ce), .out_rst(out_rst),
    .dout(dout), .empty(empty), .almost_empty(almost_empty), .rd_err(rd_err),
    .rd_busy(rd_busy), .rd_count(rd_count));

  logic        wr_en2 = 0, rd_en2 = 0;
  logic [71:0] din2 = '0, dout2;
  logic        full2, afull2, wr_err2, wr_busy2, empty2, aempty2, rd_err2, rd_busy2;
  logic [9:0]  wr_count2, rd_count2;

  dcfifo #(.SHAPE(SHAPE_72X512), .COMMON_CLK(1'b0), .FWFT(1'b1), .OUT_REG(1'b0),
           .RST_FIRST(1'b1), .RST_VAL(RSTV), .AE_THRESH(2), .AF_THRESH(10),
           .CNT_MODE(CNT_POINTER)) u_fwft (
    .wclk(wclk), .rclk(rclk2), .rst(rst), .wr_en(wr_en2), .din(din2),
    .full(full2), .almost_full(afull2), .wr_err(wr_err2), .wr_busy(wr_busy2),
    .wr_count(wr_count2), .rd_en(rd_en2), .out_ce(1'b1), .out_rst(1'b0),
    .dout(dout2), .empty(empty2), .almost_empty(aempty2), .rd_err(rd_err2),
    .rd_busy(rd_busy2), .rd_count(rd_count2));

  int n_chk = 0, n_fail = 0;
  logic [71:0] model[$];
  logic [71:0] exp_memq = RSTV, exp_dout = RSTV;

  function automatic logic [71:0] pat(int i);
    return {8'(i * 7), 32'(i) * 32'h9E37_79B9, 32'(i) ^ 32'h1234_5678};
  endfunction

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One common-clock cycle on u_dut, judged against the queue model.
  task automatic step(input logic we, input logic [71:0] d, input logic re);
    int occ;
    logic [71:0] nd;
    occ = model.size();
    wr_en = we; din = d; rd_en = re;
    @(negedge wclk);
    wr_en = 0; rd_en = 0;
    nd = out_rst ? RSTV : (out_ce ? exp_memq : exp_dout);
    if (re && occ > 0) exp_memq = model.pop_front();
    if (we && occ < DEP) model.push_back(d);
    exp_dout = nd;
    chk("R3 wr_err", 72'(wr_err), 72'(we && occ == DEP));
    chk("R4 rd_err", 72'(rd_err), 72'(re && occ == 0));
    chk("R3 full", 72'(full), 72'(model.size() == DEP));
    chk("R4 empty", 72'(empty), 72'(model.size() == 0));
    chk("R5 almost_full", 72'(almost_full), 72'(model.size() >= 508));
    chk("R6 almost_empty", 72'(almost_empty), 72'(model.size() <= 4));
    chk("R8 wr_count", 72'(wr_count), 72'(model.size()));
    chk("R11 rd_count", 72'(rd_count), 72'(model.size()));
    chk((out_rst || !out_ce) ? "R10 dout" : "R2 dout", dout, exp_dout);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int idx, guard;
    logic [71:0] wa, wb;
    // R7: reset behaviour
    repeat (3) @(negedge wclk);
    chk("R7 wr_busy in reset", 72'(wr_busy), 72'(1));
    chk("R7 rd_busy in reset", 72'(rd_busy), 72'(1));
    wr_en = 1; din = pat(999);
    @(negedge wclk);
    wr_en = 0;
    chk("R7 wr_err while busy", 72'(wr_err), 72'(1));
    repeat (2) @(negedge wclk);
    rst = 0;
    guard = 0;
    while ((wr_busy || rd_busy || wr_busy2 || rd_busy2) && guard < 40) begin
      @(negedge wclk); guard++;
    end
    chk("R7 busy released", 72'(wr_busy | rd_busy | wr_busy2 | rd_busy2), 72'(0));
    chk("R7 empty after reset", 72'(empty), 72'(1));
    chk("R7 wr_count after reset", 72'(wr_count), 72'(0));
    chk("R7 rd_count after reset", 72'(rd_count), 72'(0));
    chk("R7 dout reset value", dout, RSTV);
    chk("R1 data width", 72'($bits(dout)), 72'(72));

    // R4: read while empty
    step(0, '0, 1);
    // R11: common-clock flag follows write at once
    step(1, pat(0), 0);
    chk("R11 empty falls after one write", 72'(empty), 72'(0));
    // R1/R3/R5: fill to exactly DEPTH
    for (int i = 1; i < DEP; i++) step(1, pat(i), 0);
    chk("R1 depth reached at 512", 72'(full), 72'(1));
    step(1, pat(900), 0);
    step(1, pat(901), 0);
    // R12 boundary: read and write together at full
    step(1, pat(902), 1);
    chk("R12 full: write dropped read taken", 72'(wr_count), 72'(DEP - 1));
    while (model.size() > 256) step(0, '0, 1);
    // R12: both requests at half occupancy
    for (int k = 0; k < 50; k++) step(1, pat(1000 + k), 1);
    chk("R12 count steady", 72'(rd_count), 72'(256));
    while (model.size() > 0) step(0, '0, 1);
    step(0, '0, 0);
    // R12 boundary: read and write together at empty
    step(1, pat(2000), 1);
    chk("R12 empty: write taken read refused", 72'(rd_count), 72'(1));
    step(0, '0, 1);
    step(0, '0, 0);
    // R2: after wrap-around
    for (int k = 0; k < 300; k++) step(1, pat(3000 + k), 0);
    while (model.size() > 0) step(0, '0, 1);
    step(0, '0, 0);

    // R10: output register enable and reset
    wa = pat(4000); wb = pat(4001);
    step(1, wa, 0);
    step(1, wb, 0);
    step(0, '0, 1);
    step(0, '0, 0);
    chk("R10 dout after pipeline", dout, wa);
    out_ce = 0;
    step(0, '0, 1);
    chk("R10 hold while enable low", dout, wa);
    out_ce = 1;
    step(0, '0, 0);
    chk("R10 load when enable high", dout, wb);
    out_ce = 0; out_rst = 1;
    step(0, '0, 0);
    chk("R10 reset wins over enable", dout, RSTV);
    out_ce = 1; out_rst = 0;
    step(0, '0, 0);
    chk("R10 reload after reset", dout, wb);

    // R9/R8: fall-through instance with separate clocks
    for (int k = 0; k < 20; k++) begin
      @(negedge wclk); wr_en2 = 1; din2 = pat(5000 + k);
    end
    @(negedge wclk); wr_en2 = 0;
    repeat (12) @(negedge rclk2);
    chk("R9 word shown without read", dout2, pat(5000));
    chk("R9 empty clear without read", 72'(empty2), 72'(0));
    chk("R8 pointer count after prefetch", 72'(rd_count2), 72'(1));
    chk("R8 write pointer", 72'(wr_count2), 72'(20));
    idx = 0; guard = 0;
    while (idx < 20 && guard < 400) begin
      if (!empty2) begin
        chk("R9 fall-through order", dout2, pat(5000 + idx));
        rd_en2 = 1; idx++;
      end else rd_en2 = 0;
      @(negedge rclk2); guard++;
    end
    rd_en2 = 0;
    repeat (4) @(negedge rclk2);
    chk("R9 empty after drain", 72'(empty2), 72'(1));
    chk("R6 almost_empty after drain", 72'(aempty2), 72'(1));
    chk("R8 read pointer after drain", 72'(rd_count2), 72'(20));
    rd_en2 = 1;
    @(negedge rclk2);
    rd_en2 = 0;
    chk("R4 fall-through read on empty", 72'(rd_err2), 72'(1));
    chk("R4 pointer unchanged", 72'(rd_count2), 72'(20));

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule